// File: doc/BRIEF.md
# Nibble-Written Character Bank Map

This block keeps eight character bank registers of eight bits each. Each register picks one 1 KB page for one eighth of the 8 KB pattern space seen by the picture bus. Software never writes a whole register at once. A CPU store into the window 0xB000–0xEFFF carries four useful bits, and the store address picks the target register and which half of it takes those bits. A full bank number therefore takes two stores, and the half that is not addressed keeps its value.

On the lookup side, the top three bits of the 13-bit picture address pick a register. Its value, reduced modulo the number of physical character banks, is driven out as the bank number. The lookup is combinational on the register outputs. A store therefore shows on the first lookup after the clock edge that takes it.

Top module: `chrbank_nibble_map`

## Requirements
- R1: Synchronous active-low reset clears all eight registers, so every picture address maps to bank 0 once reset is released.
- R2: A store uses only bits 3:0 of the write data. Bits 7:4 of the data never reach a register.
- R3: Address bit 2 is ORed into bit 0 and address bit 3 is ORed into bit 1 before decode. A store to 0xB004 acts like 0xB001, and a store to 0xB008 acts like 0xB002.
- R4: Address bits 15:12 hold 0xB, 0xC, 0xD or 0xE, giving group g = 0 to 3. The register index is 2·g + folded bit 0. Address bits 11:4 take no part in the decode.
- R5: Folded bit 1 = 0 loads the low nibble (bits 3:0) and folded bit 1 = 1 loads the high nibble (bits 7:4). The other nibble is kept. Example: 0xAB then 0x05 to 0xB000 gives 0xA5, and 0xAB then 0x05 to 0xB002 gives 0x5B.
- R6: A store changes no register when its address lies outside 0xB000–0xEFFF or when the write strobe is low.
- R7: Picture address bits 12:10 = i select register i. Addresses i·0x400 through i·0x400+0x3FF all map to the same register.
- R8: The bank output is the selected register value modulo the parameter CHR_BANKS.
- R9: A store becomes visible on the bank output right after the clock edge that samples it. Before that edge, the old value is still driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU store address |
| cpu_wdata | input | 8 | CPU store data; only bits 3:0 are used |
| cpu_we | input | 1 | CPU write strobe |
| ppu_addr | input | 13 | Picture-bus pattern address |
| chr_bank | output | BANK_W (8) | Physical 1 KB character bank for ppu_addr |

## Verification
Each register is filled by separate low and high stores. The data carries non-zero upper bits, so a design that keeps the whole byte shows up as a wrong bank number. Stores go to plain addresses and to addresses with bit 2, bit 3 or bit 11 set. These separate correct address folding from a plain bit-0/bit-1 decode and from decode that uses too many address bits. Stores outside the window and stores with the strobe low are each followed by a full sweep of all eight slots at both ends of each 1 KB range. A second instance with a bank count that is not a power of two checks the modulo path against the mask path.

// File: rtl/chrbank_pkg.sv
`timescale 1ns/1ps
// Shared widths and the decoded-store record for the character bank map.
// Assumes eight registers whose width is exactly two nibbles.
package chrbank_pkg;
    localparam int NUM_REGS = 8;
    localparam int REG_W    = 8;
    localparam int NIB_W    = REG_W / 2;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef struct packed {
        logic             hit;   // store lands in the character window
        logic [IDX_W-1:0] idx;   // target register
        logic             hi;    // 1: upper nibble, 0: lower nibble
    } chr_wr_t;
endpackage

// File: rtl/chrbank_wr_decode.sv
`timescale 1ns/1ps
// Turns a CPU store into a register index and a nibble select.
// Address bits 3:2 are folded onto 1:0 first. Bits 11:4 are not decoded.
// Assumes the window covers exactly four 4 KB groups from 0xB000 upward.
module chrbank_wr_decode
    import chrbank_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_we,
    output chr_wr_t     wr
);
    logic [3:0] grp;
    logic       in_window;
    logic       fold0;
    logic       fold1;
    logic       unused_addr;

    assign unused_addr = ^cpu_addr[11:4];

    // Window detect, fold and index build
    always_comb begin
        in_window = (cpu_addr[15:12] >= 4'hB) && (cpu_addr[15:12] <= 4'hE);
        fold0     = cpu_addr[0] | cpu_addr[2];
        fold1     = cpu_addr[1] | cpu_addr[3];
        grp       = cpu_addr[15:12] - 4'hB;
        wr.hit    = cpu_we && in_window;
        wr.idx    = {grp[1:0], fold0};
        wr.hi     = fold1;
    end
endmodule

// File: rtl/chrbank_regfile.sv
`timescale 1ns/1ps
// Eight bank registers, each loaded one nibble at a time.
// Assumes the store record is already decoded. The half that is not addressed holds.
module chrbank_regfile
    import chrbank_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  chr_wr_t                         wr,
    input  logic [NIB_W-1:0]                nib,
    output logic [NUM_REGS-1:0][REG_W-1:0]  regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] word_q;
        logic             sel;

        assign sel = wr.hit && (wr.idx == IDX_W'(g));

        // Per-register nibble load with synchronous clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (sel) begin
                if (wr.hi) word_q[REG_W-1:NIB_W] <= nib;
                else       word_q[NIB_W-1:0]     <= nib;
            end
        end

        assign regs_o[g] = word_q;
    end
endmodule

// File: rtl/chrbank_lookup.sv
`timescale 1ns/1ps
// Picks the register for a picture-bus slot and reduces it to a physical bank.
// A power-of-two bank count uses a mask. Any other count uses a constant modulo.
// Assumes CHR_BANKS is at most 2**REG_W.
module chrbank_lookup
    import chrbank_pkg::*;
#(
    parameter int CHR_BANKS = 256,
    parameter int BANK_W    = 8
)(
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
    input  logic [IDX_W-1:0]               slot,
    output logic [BANK_W-1:0]              bank
);
    localparam bit POW2 = (CHR_BANKS & (CHR_BANKS - 1)) == 0;

    logic [REG_W-1:0] sel;
    logic             unused_sel;

    assign sel        = regs[slot];
    assign unused_sel = ^sel;

    if (POW2) begin : g_mask
        assign bank = sel[BANK_W-1:0];
    end else begin : g_mod
        logic [REG_W-1:0] rem;
        // Constant-divisor reduction
        always_comb rem = sel % REG_W'(CHR_BANKS);
        assign bank = rem[BANK_W-1:0];
    end
endmodule

// File: rtl/chrbank_nibble_map.sv
`timescale 1ns/1ps
// Top: nibble-written character bank registers plus picture-address lookup.
// Stores are sampled on clk. The lookup is combinational on the registers.
// Assumes a 16-bit CPU address and a 13-bit picture address.
module chrbank_nibble_map
    import chrbank_pkg::*;
#(
    parameter int CHR_BANKS = 256,
    parameter int BANK_W    = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    parameter int PPU_AW    = 13
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [BANK_W-1:0] chr_bank
);
    localparam int SLOT_LSB = PPU_AW - IDX_W;

    chr_wr_t                        wr;
    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
    logic                           unused_in;

    assign unused_in = ^{cpu_wdata[7:NIB_W], ppu_addr[SLOT_LSB-1:0]};

    chrbank_wr_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_we   (cpu_we),
        .wr       (wr)
    );

    chrbank_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr),
        .nib    (cpu_wdata[NIB_W-1:0]),
        .regs_o (regs_q)
    );

    chrbank_lookup #(
        .CHR_BANKS (CHR_BANKS),
        .BANK_W    (BANK_W)
    ) u_look (
        .regs (regs_q),
        .slot (ppu_addr[PPU_AW-1:SLOT_LSB]),
        .bank (chr_bank)
    );
endmodule

// File: rtl/chrbank_nibble_map_chk.sv
`timescale 1ns/1ps
// Checker for chrbank_nibble_map. It rebuilds the store decode from the ports
// and watches the register outputs and the bank output over time.
module chrbank_nibble_map_chk #(
    parameter int CHR_BANKS = 256,
    parameter int BANK_W    = 8,
    parameter int PPU_AW    = 13
)(
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_we,
    input logic [PPU_AW-1:0] ppu_addr,
    input logic [BANK_W-1:0] chr_bank,
    input logic [63:0]       bank_regs
);
    logic       wr_hit;
    logic [2:0] k_idx;
    logic       k_hi;
    logic [3:0] gsub;
    logic       unused_chk;

    assign unused_chk = ^{cpu_addr[11:4], cpu_wdata[7:4]};
    assign wr_hit = cpu_we && (cpu_addr[15:12] inside {4'hB, 4'hC, 4'hD, 4'hE});
    assign gsub   = cpu_addr[15:12] - 4'hB;
    assign k_idx  = {gsub[1:0], cpu_addr[0] | cpu_addr[2]};
    assign k_hi   = cpu_addr[1] | cpu_addr[3];

    function automatic logic [7:0] word_at(input logic [63:0] r, input logic [2:0] k);
        return r[k*8 +: 8];
    endfunction

    logic              after_rst_q;
    logic              live_q;
    logic              wr_q;
    logic              hi_q;
    logic [2:0]        idx_q;
    logic [3:0]        dat_q;
    logic [7:0]        old_q;
    logic [63:0]       regs_prev_q;
    logic [PPU_AW-1:0] ppu_prev_q;
    logic [BANK_W-1:0] bank_prev_q;

    // History of the previous sampled cycle
    always_ff @(posedge clk) begin
        after_rst_q <= !rst_n;
        if (!rst_n) begin
            live_q      <= 1'b0;
            wr_q        <= 1'b0;
            hi_q        <= 1'b0;
            idx_q       <= '0;
            dat_q       <= '0;
            old_q       <= '0;
            regs_prev_q <= '0;
            ppu_prev_q  <= '0;
            bank_prev_q <= '0;
        end else begin
            live_q      <= 1'b1;
            wr_q        <= wr_hit;
            hi_q        <= k_hi;
            idx_q       <= k_idx;
            dat_q       <= cpu_wdata[3:0];
            old_q       <= word_at(bank_regs, k_idx);
            regs_prev_q <= bank_regs;
            ppu_prev_q  <= ppu_addr;
            bank_prev_q <= chr_bank;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst_q |-> (bank_regs == 64'd0));

    // R5
    low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && wr_q && !hi_q) |->
        (word_at(bank_regs, idx_q) == {old_q[7:4], dat_q}));

    // R5
    high_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && wr_q && hi_q) |->
        (word_at(bank_regs, idx_q) == {dat_q, old_q[3:0]}));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !wr_q) |-> (bank_regs == regs_prev_q));

    // R9
    lookup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !wr_q && (ppu_addr == ppu_prev_q)) |-> (chr_bank == bank_prev_q));

    // R8
    always_ff @(posedge clk) begin
        if (rst_n) begin
            bank_range_chk: assert (int'(chr_bank) < CHR_BANKS);
        end
    end
endmodule

bind chrbank_nibble_map chrbank_nibble_map_chk #(
    .CHR_BANKS (CHR_BANKS),
    .BANK_W    (BANK_W),
    .PPU_AW    (PPU_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .ppu_addr  (ppu_addr),
    .chr_bank  (chr_bank),
    .bank_regs (regs_q)
);

// File: tb/chrbank_nibble_map_test.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers push expected register values and a monitor
// compares both instances (mask path and modulo-12 path) after each negedge.
module chrbank_nibble_map_test;
    localparam int MODB = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic [7:0]  chr_bank;
    logic [3:0]  chr_bank_m;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chrbank_nibble_map uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .ppu_addr(ppu_addr), .chr_bank(chr_bank)
    );

    chrbank_nibble_map #(.CHR_BANKS(MODB)) uut_mod (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .ppu_addr(ppu_addr), .chr_bank(chr_bank_m)
    );

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] model [8];

    // Expected-register update written from R2..R6
    function automatic void model_store(input logic [15:0] a, input logic [7:0] d, input bit we);
        int g;
        int k;
        if (!we || a[15:12] < 4'hB || a[15:12] > 4'hE) return;
        g = int'(a[15:12]) - 11;
        k = g * 2 + int'(a[0] | a[2]);
        if (a[1] | a[3]) model[k][7:4] = d[3:0];
        else             model[k][3:0] = d[3:0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        foreach (model[i]) model[i] = 8'h00;
    endtask

    task automatic store(input logic [15:0] a, input logic [7:0] d, input bit we = 1'b1);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = we;
        model_store(a, d, we);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic look(input logic [12:0] pa, input string tag);
        exp_t e;
        @(negedge clk);
        ppu_addr = pa;
        e.val = model[pa[12:10]];
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 8; i++) begin
            look(13'(i * 13'h400), tag);
            look(13'(i * 13'h400 + 13'h3FF), tag);
        end
    endtask

    // R9: old value before the edge, new value right after it
    task automatic store_and_look(input logic [15:0] a, input logic [7:0] d, input logic [12:0] pa);
        exp_t e;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; ppu_addr = pa;
        e.val = model[pa[12:10]]; e.tag = "R9 before edge";
        sb.push_back(e);
        model_store(a, d, 1'b1);
        @(negedge clk);
        cpu_we = 1'b0;
        e.val = model[pa[12:10]]; e.tag = "R9 after edge";
        sb.push_back(e);
    endtask

    // Monitor: pop and compare both instances away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                logic [7:0] em;
                e = sb.pop_front();
                em = e.val % 8'(MODB);
                checks++;
                if (chr_bank !== e.val) begin
                    errors++;
                    $display("FAIL %s: chr_bank got %h expected %h", e.tag, chr_bank, e.val);
                end
                checks++;
                if (chr_bank_m !== em[3:0]) begin
                    errors++;
                    $display("FAIL R8 (%s): modulo bank got %h expected %h", e.tag, chr_bank_m, em[3:0]);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        foreach (model[i]) model[i] = 8'h00;
        do_reset();
        // R1: all slots zero after reset
        sweep("R1 reset state");

        // R2, R4, R7: full bytes via two stores each, junk in data bits 7:4
        for (int r = 0; r < 8; r++) begin
            logic [15:0] base;
            logic [7:0]  v;
            base = 16'hB000 + 16'((r / 2) * 16'h1000) + 16'(r % 2);
            v = 8'(8'h1E + r * 8'h23);
            store(base, {4'hF, v[3:0]});
            store(base + 16'h2, {4'hC, v[7:4]});
        end
        sweep("R2/R4/R7 all registers");

        // R5: nibble keep
        store(16'hB000, 8'h0B); store(16'hB002, 8'h0A);
        look(13'h0000, "R5 preset AB");
        store(16'hB000, 8'h05);
        look(13'h0010, "R5 low write keeps high");
        store(16'hB000, 8'h0B);
        store(16'hB002, 8'h05);
        look(13'h03F0, "R5 high write keeps low");

        // R3: address folding; R4: bit 11 and bits 9:4 ignored
        store(16'hB004, 8'h07);
        look(13'h0400, "R3 B004 acts as B001");
        store(16'hB008, 8'h03);
        look(13'h0000, "R3 B008 acts as B002");
        store(16'hC00C, 8'h09);
        look(13'h0C00, "R3 C00C acts as C003");
        store(16'hD800, 8'h0E);
        store(16'hE3F1, 8'h06);
        sweep("R4 bit 11 and mid bits ignored");

        // R6: outside window and strobe low
        store(16'hA000, 8'h0F);
        store(16'hF000, 8'h0F);
        store(16'hF003, 8'h0F);
        store(16'h8001, 8'h0F);
        store(16'hAFFF, 8'h0F);
        store(16'hC001, 8'h0F, 1'b0);
        sweep("R6 no effect");

        // R9
        store_and_look(16'hE002, 8'h0D, 13'h1800);
        store_and_look(16'hD001, 8'h02, 13'h1400);

        // R8: values past 12 on the modulo instance
        store(16'hB001, 8'h0F); store(16'hB003, 8'h0F);
        look(13'h0400, "R8 value FF");
        store(16'hB001, 8'h0C); store(16'hB003, 8'h00);
        look(13'h0400, "R8 value 0C");

        // R1 again after a mid-run reset
        do_reset();
        sweep("R1 second reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule